// File: doc/BRIEF.md
# LCD Parallel Bus Sequencer

This block moves single bytes between a host-side byte register and an 8-bit parallel display bus. A host or DMA write request loads a byte and starts a bus write. A read request starts a bus read, which captures a byte from the bus into the read-data register. Two signalling styles are available on the two control pins. In the separate-strobe style the pins are an active-low write strobe and an active-low read strobe. In the direction-plus-enable style the first pin gives the transfer direction and the second pin is an enable pulse. The polarity of the enable pulse sets which of its edges is the active one.

An access lasts a programmed number of clock cycles C. The first cycle is setup. The strobe is then active for W+1 cycles, where W is the programmed wait-state count. The remaining cycles hold address and data. An interrupt pulse tells the host or DMA that the next byte may be supplied. A select input places the pulse either where the strobe ends or in the final cycle of the access. Configuration is captured when a request is accepted. A request made in the final cycle chains the next access with no idle gap. Settings outside the legal range are clamped.

The controller is a four-state machine. IDLE moves to SETUP on an accepted request. SETUP always moves to STROBE. STROBE moves to HOLD when its counter expires. HOLD returns to IDLE when its counter expires, or goes straight to SETUP if a request arrives in that final cycle.

Top module: `lcd_bus_ctrl`

## Requirements
- R1: On a write access, `bus_oe` is 1 and `bus_out` equals the byte written, for all C cycles of the access.
- R2: On a read access, `bus_oe` is 0. `bus_in` is sampled at the clock edge that ends the last strobe cycle, and `rd_data` shows that byte from the next cycle until the next read.
- R3: With `cfg_mode`=0, `pin_a` is low only during the strobe cycles of a write, and `pin_b` is low only during the strobe cycles of a read. Both pins are high at all other times.
- R4: With `cfg_mode`=1, `pin_a` is 1 during a read access, 0 during a write access, and 1 when idle. `pin_b` is the enable. With `cfg_edge`=0 the enable is a high pulse (falling edge active). With `cfg_edge`=1 it is a low pulse (rising edge active). `pin_b` sits at the inactive level outside the strobe cycles.
- R5: Numbering the access cycles from 0, cycle 0 has the strobe inactive, cycles 1 to W+1 have it active, and cycles W+2 to C-1 have it inactive. The access lasts exactly C cycles.
- R6: A programmed C below 3 is used as 3. A programmed W above C-3 is used as C-3. The strobe is therefore always inactive in the final cycle of an access.
- R7: With `cfg_irq_sel`=0, `irq` is a one-cycle pulse in cycle W+2, the first cycle after the strobe ends.
- R8: With `cfg_irq_sel`=1, `irq` is a one-cycle pulse in cycle C-1, the final cycle of the access.
- R9: `busy` is 1 in every cycle of an access and 0 when idle. `irq` and `bus_oe` are never 1 while `busy` is 0.
- R10: Requests, data and configuration inputs presented in any cycle of an access other than the final one have no effect. Configuration is taken only in the cycle in which a request is accepted.
- R11: A request presented in the final cycle of an access starts the next access in the following cycle, with `busy` staying at 1.
- R12: When `wr_req` and `rd_req` are both asserted, the access is a write. During reset, `busy`, `irq` and `bus_oe` are 0, both pins are high, and `rd_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_cycles | input | CYC_W | Access length C in clocks |
| cfg_wait | input | WST_W | Wait-state count W |
| cfg_mode | input | 1 | 0: separate strobes, 1: direction plus enable |
| cfg_edge | input | 1 | Enable polarity in mode 1 (0: high pulse, 1: low pulse) |
| cfg_irq_sel | input | 1 | 0: irq where the strobe ends, 1: irq in the final cycle |
| wr_req | input | 1 | Write-request pulse with byte on wr_data |
| wr_data | input | DW | Byte to write |
| rd_req | input | 1 | Read-request pulse |
| rd_data | output | DW | Last byte read from the bus |
| busy | output | 1 | Access in progress |
| irq | output | 1 | Next-byte request pulse |
| bus_out | output | DW | Bus drive value |
| bus_oe | output | 1 | Bus drive enable |
| bus_in | input | DW | Bus input value |
| pin_a | output | 1 | Write strobe (mode 0) or direction (mode 1) |
| pin_b | output | 1 | Read strobe (mode 0) or enable (mode 1) |

## Verification
The hardest situation to reach is a request arriving in exactly the final cycle of an access. This is also the only window in which a request is not ignored while `busy` is high, and it must chain without a gap. The stimulus places the next request on the last cycle of one access in about a third of the random accesses. It also injects junk requests and configuration changes in an earlier cycle of every access, so that the accepting and the ignoring windows are both exercised. For reads, the bench presents the valid byte on `bus_in` only during the single cycle before the sampling edge, so sampling one cycle early or late is caught.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_HOLD   = 2'd3
    } lb_state_t;
endpackage

// File: rtl/lcd_bus_timing.sv
// Clamps the programmed cycle and wait values and derives phase lengths.
module lcd_bus_timing #(
    parameter int CYC_W = 5,
    parameter int WST_W = 5
) (
    input  logic [CYC_W-1:0] cyc,
    input  logic [WST_W-1:0] wst,
    output logic [CYC_W-1:0] strb_len,
    output logic [CYC_W-1:0] hold_len
);
    localparam int XW = ((CYC_W > WST_W) ? CYC_W : WST_W) + 1;

    logic [XW-1:0] cyc_x;
    logic [XW-1:0] wst_x;
    logic [XW-1:0] lim;

    always_comb begin
        cyc_x = XW'(cyc);
        if (cyc_x < XW'(3)) cyc_x = XW'(3);
        lim   = cyc_x - XW'(3);
        wst_x = XW'(wst);
        if (wst_x > lim) wst_x = lim;
        strb_len = CYC_W'(wst_x + XW'(1));
        hold_len = CYC_W'(cyc_x - wst_x - XW'(2));
    end
endmodule

// File: rtl/lcd_bus_pins.sv
// Maps the internal strobe and direction onto the two control pins.
module lcd_bus_pins (
    input  logic mode,
    input  logic edge_sel,
    input  logic active,
    input  logic is_rd,
    input  logic strobe,
    output logic pin_a,
    output logic pin_b
);
    always_comb begin
        if (!mode) begin
            pin_a = ~(strobe & ~is_rd);
            pin_b = ~(strobe & is_rd);
        end else begin
            pin_a = active ? is_rd : 1'b1;
            pin_b = strobe ^ edge_sel;
        end
    end
endmodule

// File: rtl/lcd_bus_ctrl.sv
module lcd_bus_ctrl
    import lcd_bus_pkg::*;
#(
    parameter int CYC_W = 5,
    parameter int WST_W = 5,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CYC_W-1:0] cfg_cycles,
    input  logic [WST_W-1:0] cfg_wait,
    input  logic             cfg_mode,
    input  logic             cfg_edge,
    input  logic             cfg_irq_sel,
    input  logic             wr_req,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_req,
    output logic [DW-1:0]    rd_data,
    output logic             busy,
    output logic             irq,
    output logic [DW-1:0]    bus_out,
    output logic             bus_oe,
    input  logic [DW-1:0]    bus_in,
    output logic             pin_a,
    output logic             pin_b
);
    lb_state_t        state, state_nx;
    logic [CYC_W-1:0] cnt, cnt_nx;
    logic [CYC_W-1:0] strb_len, hold_len;
    logic [CYC_W-1:0] strb_l, hold_l;
    logic             mode_l, edge_l, sel_l, is_rd_l;
    logic [DW-1:0]    wdata, rdata;
    logic             acc, last_hold, first_hold, strobe;

    lcd_bus_timing #(.CYC_W(CYC_W), .WST_W(WST_W)) u_timing (
        .cyc      (cfg_cycles),
        .wst      (cfg_wait),
        .strb_len (strb_len),
        .hold_len (hold_len)
    );

    assign last_hold  = (state == ST_HOLD) && (cnt == '0);
    assign first_hold = (state == ST_HOLD) && (cnt == hold_l - CYC_W'(1));
    assign acc        = (wr_req | rd_req) && ((state == ST_IDLE) || last_hold);

    // Next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (acc) state_nx = ST_SETUP;
            end
            ST_SETUP: begin
                state_nx = ST_STROBE;
                cnt_nx   = strb_l - CYC_W'(1);
            end
            ST_STROBE: begin
                if (cnt == '0) begin
                    state_nx = ST_HOLD;
                    cnt_nx   = hold_l - CYC_W'(1);
                end else begin
                    cnt_nx = cnt - CYC_W'(1);
                end
            end
            ST_HOLD: begin
                if (cnt == '0) state_nx = acc ? ST_SETUP : ST_IDLE;
                else           cnt_nx   = cnt - CYC_W'(1);
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // Access context captured on acceptance, read byte captured at strobe end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strb_l  <= CYC_W'(1);
            hold_l  <= CYC_W'(1);
            mode_l  <= 1'b0;
            edge_l  <= 1'b0;
            sel_l   <= 1'b0;
            is_rd_l <= 1'b1;
            wdata   <= '0;
            rdata   <= '0;
        end else begin
            if (acc) begin
                strb_l  <= strb_len;
                hold_l  <= hold_len;
                mode_l  <= cfg_mode;
                edge_l  <= cfg_edge;
                sel_l   <= cfg_irq_sel;
                is_rd_l <= ~wr_req;
                if (wr_req) wdata <= wr_data;
            end
            if ((state == ST_STROBE) && (cnt == '0) && is_rd_l) rdata <= bus_in;
        end
    end

    // Moore outputs
    always_comb begin
        busy   = (state != ST_IDLE);
        strobe = (state == ST_STROBE);
        bus_oe = busy && !is_rd_l;
        irq    = sel_l ? last_hold : first_hold;
    end

    assign bus_out = wdata;
    assign rd_data = rdata;

    lcd_bus_pins u_pins (
        .mode     (mode_l),
        .edge_sel (edge_l),
        .active   (busy),
        .is_rd    (is_rd_l),
        .strobe   (strobe),
        .pin_a    (pin_a),
        .pin_b    (pin_b)
    );
endmodule

// File: rtl/lcd_bus_ctrl_chk.sv
module lcd_bus_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic irq,
    input logic bus_oe,
    input logic strobe
);
    AST_OE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) bus_oe |-> busy); // R9
    AST_IRQ_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n) irq |-> busy); // R9
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) irq |=> !irq); // R7
    AST_SETUP_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !strobe); // R5
    AST_END_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(!strobe)); // R6
    AST_STROBE_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) strobe |-> busy); // R5
endmodule

bind lcd_bus_ctrl lcd_bus_ctrl_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .irq    (irq),
    .bus_oe (bus_oe),
    .strobe (strobe)
);

// File: tb/lcd_bus_ctrl_test.sv
module lcd_bus_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cfg_cycles = '0;
    logic [4:0] cfg_wait = '0;
    logic       cfg_mode = 1'b0, cfg_edge = 1'b0, cfg_irq_sel = 1'b0;
    logic       wr_req = 1'b0, rd_req = 1'b0;
    logic [7:0] wr_data = '0, bus_in = '0;
    logic [7:0] rd_data, bus_out;
    logic       busy, irq, bus_oe, pin_a, pin_b;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [7:0] exp_rd = 8'h00;
    logic       last_md = 1'b0, last_eg = 1'b0;

    always #10 clk = ~clk;

    lcd_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_cycles(cfg_cycles), .cfg_wait(cfg_wait),
        .cfg_mode(cfg_mode), .cfg_edge(cfg_edge), .cfg_irq_sel(cfg_irq_sel),
        .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .busy(busy), .irq(irq), .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in),
        .pin_a(pin_a), .pin_b(pin_b)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_pins(input logic md, input logic eg, input logic act,
                                            input logic rd, input logic strb);
        if (!md) return {~(strb & ~rd), ~(strb & rd)};
        return {act ? rd : 1'b1, strb ^ eg};
    endfunction

    // Caller is at a negedge; request is driven here and accepted at the next posedge.
    task automatic access(input bit rd, input bit both, input logic [7:0] d, input int cy,
                          input int ws, input logic md, input logic eg, input logic sl);
        int ec, ew;
        logic er, strb, ei;
        logic [1:0] p;
        ec = (cy < 3) ? 3 : cy;
        ew = (ws > ec - 3) ? ec - 3 : ws;
        er = rd && !both;
        wr_req = !rd || both;
        rd_req = rd || both;
        wr_data = d;
        cfg_cycles = 5'(cy); cfg_wait = 5'(ws);
        cfg_mode = md; cfg_edge = eg; cfg_irq_sel = sl;
        if (er) bus_in = ~d;
        for (int k = 0; k < ec; k++) begin
            @(negedge clk);
            if (k == 0) begin wr_req = 0; rd_req = 0; end
            strb = (k >= 1) && (k <= ew + 1);
            ei = sl ? (k == ec - 1) : (k == ew + 2);
            p = exp_pins(md, eg, 1'b1, er, strb);
            chk(busy == 1'b1, "R9 busy in access", busy, 1);
            chk(bus_oe == !er, er ? "R2 oe off on read" : "R1 oe on write", bus_oe, !er);
            if (!er) chk(bus_out == d, "R1 write data (R10 ignore)", bus_out, d);
            chk({pin_a, pin_b} == p, md ? "R4 R5 R6 mode1 pins" : "R3 R5 R6 mode0 pins",
                {pin_a, pin_b}, p);
            chk(irq == ei, sl ? "R8 irq end" : "R7 irq strobe end", irq, ei);
            if (er && k == ew + 1) chk(rd_data == exp_rd, "R2 rd_data held", rd_data, exp_rd);
            if (er && k == ec - 1) chk(rd_data == d, "R2 rd_data sampled", rd_data, d);
            if (er && k == ew + 1) bus_in = d;
            if (er && k == ew + 2) bus_in = ~d;
            if (k == 1) begin
                // R10: junk inside a non-final cycle
                wr_req = 1; rd_req = 1'($urandom); wr_data = ~d;
                cfg_cycles = 5'($urandom); cfg_wait = 5'($urandom);
                cfg_mode = 1'($urandom); cfg_edge = 1'($urandom); cfg_irq_sel = 1'($urandom);
            end
            if (k == 2) begin wr_req = 0; rd_req = 0; end
        end
        if (er) exp_rd = d;
        last_md = md; last_eg = eg;
    endtask

    task automatic idle_check(input string req);
        logic [1:0] p;
        @(negedge clk);
        p = exp_pins(last_md, last_eg, 1'b0, 1'b1, 1'b0);
        chk(busy == 0 && irq == 0 && bus_oe == 0, req, {busy, irq, bus_oe}, 0);
        chk({pin_a, pin_b} == p, "R3 R4 idle pins", {pin_a, pin_b}, p);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd1789);
        repeat (3) @(negedge clk);
        chk(busy == 0 && irq == 0 && bus_oe == 0, "R12 reset outputs", {busy, irq, bus_oe}, 0);
        chk({pin_a, pin_b} == 2'b11, "R12 reset pins", {pin_a, pin_b}, 3);
        chk(rd_data == 8'h00, "R12 reset rd_data", rd_data, 0);
        rst_n = 1;
        @(negedge clk);
        // Directed corners
        access(0, 0, 8'hA5, 3, 0, 0, 0, 0);  idle_check("R9 idle after write");
        access(1, 0, 8'h3C, 6, 2, 0, 0, 1);  idle_check("R9 idle after read");
        access(0, 0, 8'h5A, 0, 9, 1, 0, 0);  idle_check("R6 clamp low cycles");   // R6
        access(1, 0, 8'hC3, 7, 31, 1, 1, 1); idle_check("R6 clamp wait");          // R6
        access(1, 1, 8'h99, 5, 1, 0, 0, 0);  idle_check("R12 write wins");         // R12
        // R11: back to back
        access(0, 0, 8'h11, 4, 0, 1, 1, 1);
        access(1, 0, 8'h22, 3, 0, 1, 0, 0);
        access(0, 0, 8'h33, 31, 28, 0, 0, 1);
        idle_check("R11 idle after chain");
        for (int i = 0; i < 400; i++) begin
            if ($urandom % 3 != 0) idle_check("R9 idle random");
            access(1'($urandom), ($urandom % 8) == 0, 8'($urandom), int'($urandom % 32),
                   int'($urandom % 32), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        idle_check("R9 final idle");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule